// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds one fetch status register for each hardware thread (up to four) and advances it once per clock. Its inputs are the downstream stages' per-thread block and unblock pulses, a global context-switch stall, squash requests from commit and from decode, a flag from commit saying the pipeline is still squashing, and instruction-cache events. Its outputs are the status of every thread, a one-cycle pulse when a thread's status changes, the thread's fetch address triple, and a stage-active flag.

Each thread keeps four sticky stall bits, one per downstream stage. When several requests reach the same thread in the same cycle, one fixed priority order decides which one wins. A squash redirects the thread's current, next and next-next fetch addresses. Cache events move a thread through issue, retry, response and hand-back. A thread that is waiting on the cache never enters Blocked because of a stall. The stall is applied when the response arrives instead.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After synchronous reset every thread's status is Running (code 0), every change pulse is low, and each thread's addresses are RESET_PC, RESET_PC+INST_BYTES and RESET_PC+2*INST_BYTES.
- R2: Stall bit s of thread t is bit s*NUM_THREADS+t of the set and clear vectors. A set pulse makes the bit stick until a clear pulse arrives. A clear pulse is only legal when the bit is set and no set pulse arrives on it in the same cycle.
- R3: A commit squash for an active thread always wins. The next status is Squashing (code 2), and the commit addresses are loaded even if decode squashes in the same cycle.
- R4: When there is no commit squash, the still-squashing flag puts the thread into Squashing and leaves its addresses unchanged.
- R5: A decode squash loads the decode addresses and sets Squashing only when the thread is not already Squashing. When the thread is already Squashing, the decode squash is ignored and the thread returns to Running with its addresses kept.
- R6: On a squash that loads addresses, the next-next address becomes the new next address plus INST_BYTES (default 4).
- R7: When any stall bit (after this cycle's pulses) or the context-switch stall is set, the thread enters Blocked (code 3). This does not apply while the thread is in IcacheWaitResponse (6) or IcacheWaitRetry (7). With no stall and no higher request, Blocked and Squashing return to Running.
- R8: Cache events take effect only when no higher request applies. In Running, an accepted issue moves to IcacheWaitResponse (6) and a refused issue moves to IcacheWaitRetry (7). In IcacheWaitRetry, a retry grant moves to IcacheWaitResponse. In IcacheWaitResponse, a response moves to Blocked if stalled and to IcacheAccessComplete (8) otherwise. In IcacheAccessComplete, a fetch turn moves to Running. A response in any other state is ignored.
- R9: A thread whose active bit is low keeps its status.
- R10: The stage-active output is high when at least one active thread is Running, Squashing or IcacheAccessComplete.
- R11: A thread's change pulse is high for exactly the cycles in which its status differs from the previous cycle's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_active_i | input | NUM_THREADS | Threads taking part in fetch |
| stall_set_i | input | 4*NUM_THREADS | Per-stage, per-thread block pulses |
| stall_clr_i | input | 4*NUM_THREADS | Per-stage, per-thread unblock pulses |
| ctx_stall_i | input | 1 | Global context-switch stall |
| commit_squash_i | input | NUM_THREADS | Squash from commit |
| commit_pc_i | input | NUM_THREADS*ADDR_W | Redirect address from commit |
| commit_npc_i | input | NUM_THREADS*ADDR_W | Redirect next address from commit |
| rob_busy_i | input | NUM_THREADS | Commit side still squashing |
| decode_squash_i | input | NUM_THREADS | Squash from decode |
| decode_pc_i | input | NUM_THREADS*ADDR_W | Redirect address from decode |
| decode_npc_i | input | NUM_THREADS*ADDR_W | Redirect next address from decode |
| ic_issue_ok_i | input | NUM_THREADS | Cache request accepted |
| ic_issue_nack_i | input | NUM_THREADS | Cache request refused |
| ic_retry_ok_i | input | NUM_THREADS | Refused request now accepted |
| ic_resp_i | input | NUM_THREADS | Cache response arrived |
| fetch_turn_i | input | NUM_THREADS | Thread takes its fetch turn |
| status_o | output | 4*NUM_THREADS | Status code per thread |
| status_chg_o | output | NUM_THREADS | Status change pulse |
| pc_o | output | NUM_THREADS*ADDR_W | Current fetch address |
| npc_o | output | NUM_THREADS*ADDR_W | Next fetch address |
| nnpc_o | output | NUM_THREADS*ADDR_W | Next-next fetch address |
| stage_active_o | output | 1 | Some active thread can fetch |

## Verification
The bench sweeps every stage and thread through block and unblock. It also tries every combination of commit squash, still-squashing and decode squash, computing the winning address from the combination. A design with the wrong priority would load decode addresses under a commit squash, or redirect the address on a still-squashing cycle. Other cases target a thread parked on the cache: a stall must not block it, and the response must then land in Blocked. A stale response after a squash must be dropped, because a design that accepted it would report a completed access that never belonged to the thread. Inactive threads must freeze, and their status must not count toward stage-active.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int STAT_W      = 4;
    localparam int STAGE_COUNT = 4;

    typedef enum logic [STAT_W-1:0] {
        ST_RUN           = 4'd0,
        ST_IDLE          = 4'd1,
        ST_SQUASH        = 4'd2,
        ST_BLOCKED       = 4'd3,
        ST_TRAP_WAIT     = 4'd4,
        ST_QUIESCE_WAIT  = 4'd5,
        ST_IC_WAIT_RESP  = 4'd6,
        ST_IC_WAIT_RETRY = 4'd7,
        ST_IC_DONE       = 4'd8
    } fstat_e;

    typedef struct packed {
        logic commit_sq;
        logic rob_busy;
        logic decode_sq;
        logic stalled;
        logic issue_ok;
        logic issue_nack;
        logic retry_ok;
        logic resp;
        logic turn;
    } freq_t;

    typedef struct packed {
        fstat_e nxt;
        logic   take_commit;
        logic   take_decode;
    } fres_t;

    function automatic logic fsc_can_fetch(fstat_e s);
        return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_IC_DONE);
    endfunction

    // Fixed-priority resolution of one thread's requests.
    function automatic fres_t fsc_resolve(fstat_e cur, freq_t r);
        fres_t res;
        res.nxt         = cur;
        res.take_commit = 1'b0;
        res.take_decode = 1'b0;
        if (r.commit_sq) begin
            res.nxt         = ST_SQUASH;
            res.take_commit = 1'b1;
        end else if (r.rob_busy) begin
            res.nxt = ST_SQUASH;
        end else if (r.decode_sq && (cur != ST_SQUASH)) begin
            res.nxt         = ST_SQUASH;
            res.take_decode = 1'b1;
        end else if (r.stalled && (cur != ST_IC_WAIT_RESP) && (cur != ST_IC_WAIT_RETRY)) begin
            res.nxt = ST_BLOCKED;
        end else if ((cur == ST_BLOCKED) || (cur == ST_SQUASH)) begin
            res.nxt = ST_RUN;
        end else begin
            case (cur)
                ST_IC_WAIT_RESP:  if (r.resp) res.nxt = r.stalled ? ST_BLOCKED : ST_IC_DONE;
                ST_IC_WAIT_RETRY: if (r.retry_ok) res.nxt = ST_IC_WAIT_RESP;
                ST_IC_DONE:       if (r.turn) res.nxt = ST_RUN;
                ST_RUN: begin
                    if (r.issue_ok)        res.nxt = ST_IC_WAIT_RESP;
                    else if (r.issue_nack) res.nxt = ST_IC_WAIT_RETRY;
                end
                default: res.nxt = cur;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/fsc_stall_track.sv
module fsc_stall_track #(
    parameter int NUM_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STAGES-1:0] set_i,
    input  logic [NUM_STAGES-1:0] clr_i,
    output logic                  stalled_o
);
    logic [NUM_STAGES-1:0] bits_q;
    logic [NUM_STAGES-1:0] bits_d;

    assign bits_d    = (bits_q | set_i) & ~clr_i;
    assign stalled_o = |bits_d;

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= bits_d;
    end

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_chk
        AST_UNBLOCK_LEGAL: assert property (@(posedge clk) disable iff (rst)
            clr_i[s] |-> (bits_q[s] && !set_i[s])); // R2
        AST_BLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
            set_i[s] |=> bits_q[s]); // R2
    end

endmodule

// File: rtl/fsc_thread_ctrl.sv
module fsc_thread_ctrl
    import fsc_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          INST_BYTES = 4,
    parameter logic [31:0] RESET_PC   = 32'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  freq_t             req_i,
    input  logic [ADDR_W-1:0] commit_pc_i,
    input  logic [ADDR_W-1:0] commit_npc_i,
    input  logic [ADDR_W-1:0] decode_pc_i,
    input  logic [ADDR_W-1:0] decode_npc_i,
    output fstat_e            status_o,
    output logic              changed_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] npc_o,
    output logic [ADDR_W-1:0] nnpc_o
);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INST_BYTES);
    localparam logic [ADDR_W-1:0] PC0   = ADDR_W'(RESET_PC);

    fstat_e            status_q;
    logic              changed_q;
    logic [ADDR_W-1:0] pc_q, npc_q, nnpc_q;
    fres_t             res;

    always_comb begin
        res = fsc_resolve(status_q, req_i);
        if (!active_i) begin
            res.nxt         = status_q;
            res.take_commit = 1'b0;
            res.take_decode = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= ST_RUN;
            changed_q <= 1'b0;
            pc_q      <= PC0;
            npc_q     <= PC0 + STEP;
            nnpc_q    <= PC0 + STEP + STEP;
        end else begin
            status_q  <= res.nxt;
            changed_q <= (res.nxt != status_q);
            if (res.take_commit) begin
                pc_q   <= commit_pc_i;
                npc_q  <= commit_npc_i;
                nnpc_q <= commit_npc_i + STEP;
            end else if (res.take_decode) begin
                pc_q   <= decode_pc_i;
                npc_q  <= decode_npc_i;
                nnpc_q <= decode_npc_i + STEP;
            end
        end
    end

    assign status_o  = status_q;
    assign changed_o = changed_q;
    assign pc_o      = pc_q;
    assign npc_o     = npc_q;
    assign nnpc_o    = nnpc_q;

    AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (rst)
        (active_i && req_i.commit_sq) |=> (status_q == ST_SQUASH)); // R3
    AST_COMMIT_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (active_i && req_i.commit_sq) |=> (pc_q == $past(commit_pc_i)
            && nnpc_q == $past(commit_npc_i) + STEP)); // R6
    AST_RETRY_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (status_q == ST_IC_WAIT_RETRY) |=> (status_q != ST_BLOCKED)); // R7
    AST_INACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> $stable(status_q)); // R9
    AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (rst)
        changed_q |-> (status_q != $past(status_q))); // R11

endmodule

// File: rtl/fsc_active_detect.sv
module fsc_active_detect
    import fsc_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS*STAT_W-1:0] status_i,
    input  logic [NUM_THREADS-1:0]        active_i,
    output logic                          stage_active_o
);
    logic [NUM_THREADS-1:0] hit;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_hit
        assign hit[t] = active_i[t] && fsc_can_fetch(fstat_e'(status_i[t*STAT_W +: STAT_W]));
    end

    assign stage_active_o = |hit;

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int          NUM_THREADS = 4,
    parameter int          ADDR_W      = 32,
    parameter int          INST_BYTES  = 4,
    parameter logic [31:0] RESET_PC    = 32'h100
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_THREADS-1:0]             thread_active_i,
    input  logic [STAGE_COUNT*NUM_THREADS-1:0] stall_set_i,
    input  logic [STAGE_COUNT*NUM_THREADS-1:0] stall_clr_i,
    input  logic                               ctx_stall_i,
    input  logic [NUM_THREADS-1:0]             commit_squash_i,
    input  logic [NUM_THREADS*ADDR_W-1:0]      commit_pc_i,
    input  logic [NUM_THREADS*ADDR_W-1:0]      commit_npc_i,
    input  logic [NUM_THREADS-1:0]             rob_busy_i,
    input  logic [NUM_THREADS-1:0]             decode_squash_i,
    input  logic [NUM_THREADS*ADDR_W-1:0]      decode_pc_i,
    input  logic [NUM_THREADS*ADDR_W-1:0]      decode_npc_i,
    input  logic [NUM_THREADS-1:0]             ic_issue_ok_i,
    input  logic [NUM_THREADS-1:0]             ic_issue_nack_i,
    input  logic [NUM_THREADS-1:0]             ic_retry_ok_i,
    input  logic [NUM_THREADS-1:0]             ic_resp_i,
    input  logic [NUM_THREADS-1:0]             fetch_turn_i,
    output logic [NUM_THREADS*STAT_W-1:0]      status_o,
    output logic [NUM_THREADS-1:0]             status_chg_o,
    output logic [NUM_THREADS*ADDR_W-1:0]      pc_o,
    output logic [NUM_THREADS*ADDR_W-1:0]      npc_o,
    output logic [NUM_THREADS*ADDR_W-1:0]      nnpc_o,
    output logic                               stage_active_o
);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [STAGE_COUNT-1:0] set_v, clr_v;
        logic                   stage_stall;
        freq_t                  req;
        fstat_e                 st;

        for (genvar s = 0; s < STAGE_COUNT; s++) begin : g_stg
            assign set_v[s] = stall_set_i[s*NUM_THREADS + t];
            assign clr_v[s] = stall_clr_i[s*NUM_THREADS + t];
        end

        fsc_stall_track #(.NUM_STAGES(STAGE_COUNT)) u_stall (
            .clk      (clk),
            .rst      (rst),
            .set_i    (set_v),
            .clr_i    (clr_v),
            .stalled_o(stage_stall)
        );

        always_comb begin
            req.commit_sq  = commit_squash_i[t];
            req.rob_busy   = rob_busy_i[t];
            req.decode_sq  = decode_squash_i[t];
            req.stalled    = stage_stall || ctx_stall_i;
            req.issue_ok   = ic_issue_ok_i[t];
            req.issue_nack = ic_issue_nack_i[t];
            req.retry_ok   = ic_retry_ok_i[t];
            req.resp       = ic_resp_i[t];
            req.turn       = fetch_turn_i[t];
        end

        fsc_thread_ctrl #(
            .ADDR_W    (ADDR_W),
            .INST_BYTES(INST_BYTES),
            .RESET_PC  (RESET_PC)
        ) u_ctrl (
            .clk         (clk),
            .rst         (rst),
            .active_i    (thread_active_i[t]),
            .req_i       (req),
            .commit_pc_i (commit_pc_i[t*ADDR_W +: ADDR_W]),
            .commit_npc_i(commit_npc_i[t*ADDR_W +: ADDR_W]),
            .decode_pc_i (decode_pc_i[t*ADDR_W +: ADDR_W]),
            .decode_npc_i(decode_npc_i[t*ADDR_W +: ADDR_W]),
            .status_o    (st),
            .changed_o   (status_chg_o[t]),
            .pc_o        (pc_o[t*ADDR_W +: ADDR_W]),
            .npc_o       (npc_o[t*ADDR_W +: ADDR_W]),
            .nnpc_o      (nnpc_o[t*ADDR_W +: ADDR_W])
        );

        assign status_o[t*STAT_W +: STAT_W] = st;
    end

    fsc_active_detect #(.NUM_THREADS(NUM_THREADS)) u_act (
        .status_i      (status_o),
        .active_i      (thread_active_i),
        .stage_active_o(stage_active_o)
    );

endmodule

// File: tb/tb_fetch_status_ctrl.sv
`timescale 1ns/1ps
module tb_fetch_status_ctrl;
    localparam int NT = 4;
    localparam int AW = 32;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NT-1:0]    active;
    logic [NS*NT-1:0] sset, sclr;
    logic             ctx;
    logic [NT-1:0]    csq, rob, dsq, iok, inack, rok, resp, turn;
    logic [NT*AW-1:0] cpc, cnpc, dpc, dnpc;
    logic [NT*4-1:0]  status;
    logic [NT-1:0]    chg;
    logic [NT*AW-1:0] pc, npc, nnpc;
    logic             sact;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    fetch_status_ctrl #(.NUM_THREADS(NT), .ADDR_W(AW), .INST_BYTES(4), .RESET_PC(32'h100)) dut (
        .clk(clk), .rst(rst), .thread_active_i(active),
        .stall_set_i(sset), .stall_clr_i(sclr), .ctx_stall_i(ctx),
        .commit_squash_i(csq), .commit_pc_i(cpc), .commit_npc_i(cnpc),
        .rob_busy_i(rob), .decode_squash_i(dsq), .decode_pc_i(dpc), .decode_npc_i(dnpc),
        .ic_issue_ok_i(iok), .ic_issue_nack_i(inack), .ic_retry_ok_i(rok),
        .ic_resp_i(resp), .fetch_turn_i(turn),
        .status_o(status), .status_chg_o(chg), .pc_o(pc), .npc_o(npc), .nnpc_o(nnpc),
        .stage_active_o(sact)
    );

    function automatic logic [3:0] st(int t);
        return status[t*4 +: 4];
    endfunction
    function automatic logic [AW-1:0] pcv(int t);
        return pc[t*AW +: AW];
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_pulses();
        sset = '0; sclr = '0; ctx = 1'b0; csq = '0; rob = '0; dsq = '0;
        iok = '0; inack = '0; rok = '0; resp = '0; turn = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clear_pulses();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] exp_pc;
        active = '1; cpc = '0; cnpc = '0; dpc = '0; dnpc = '0;
        clear_pulses();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int t = 0; t < NT; t++) begin
            chk("R1", "status", st(t), 4'd0);
            chk("R1", "pc", pcv(t), 32'h100);
            chk("R1", "nnpc", nnpc[t*AW +: AW], 32'h108);
        end
        chk("R1", "npc", npc[0 +: AW], 32'h104);
        chk("R1", "chg", chg, 4'b0);
        chk("R10", "stage active after reset", sact, 1'b1);

        // R2/R7/R11 sweep of every stage and thread
        for (int s = 0; s < NS; s++) begin
            for (int t = 0; t < NT; t++) begin
                sset[s*NT+t] = 1'b1; tick();
                chk("R7", "blocked on set", st(t), 4'd3);
                chk("R11", "change pulse", chg[t], 1'b1);
                tick();
                chk("R2", "stall sticky", st(t), 4'd3);
                chk("R11", "no pulse while held", chg[t], 1'b0);
                sclr[s*NT+t] = 1'b1; tick();
                chk("R7", "unblocked to running", st(t), 4'd0);
            end
        end

        // R7/R10 context stall
        ctx = 1'b1; tick();
        for (int t = 0; t < NT; t++) chk("R7", "ctx blocked", st(t), 4'd3);
        chk("R10", "all blocked inactive", sact, 1'b0);
        tick();
        for (int t = 0; t < NT; t++) chk("R7", "ctx release", st(t), 4'd0);

        // R3/R4/R5/R6 priority sweep on thread 1
        exp_pc = 32'h100;
        for (int m = 1; m < 8; m++) begin
            cpc[AW +: AW]  = 32'h1000 + 32'(m*16);
            cnpc[AW +: AW] = 32'h1004 + 32'(m*16);
            dpc[AW +: AW]  = 32'h2000 + 32'(m*16);
            dnpc[AW +: AW] = 32'h2004 + 32'(m*16);
            csq[1] = m[0]; rob[1] = m[1]; dsq[1] = m[2];
            if (m[0])      exp_pc = 32'h1000 + 32'(m*16);
            else if (!m[1] && m[2]) exp_pc = 32'h2000 + 32'(m*16);
            tick();
            chk("R3", "squash status", st(1), 4'd2);
            chk("R4", "winning pc", pcv(1), exp_pc);
            chk("R6", "nnpc step", nnpc[AW +: AW], npc[AW +: AW] + 32'd4);
            tick();
            chk("R5", "back to running", st(1), 4'd0);
        end

        // R5 decode squash ignored while squashing
        rob[2] = 1'b1; tick();
        chk("R4", "rob squash", st(2), 4'd2);
        dsq[2] = 1'b1; dpc[2*AW +: AW] = 32'h3000; dnpc[2*AW +: AW] = 32'h3004; tick();
        chk("R5", "dsq while squashing status", st(2), 4'd0);
        chk("R5", "dsq while squashing pc", pcv(2), 32'h100);

        // R8 cache flow on thread 3
        iok[3] = 1'b1; tick();
        chk("R8", "issue ok", st(3), 4'd6);
        sset[0*NT+3] = 1'b1; tick();
        chk("R7", "wait resp not blocked", st(3), 4'd6);
        resp[3] = 1'b1; tick();
        chk("R8", "resp with stall", st(3), 4'd3);
        sclr[0*NT+3] = 1'b1; tick();
        chk("R7", "release after resp", st(3), 4'd0);
        inack[3] = 1'b1; tick();
        chk("R8", "issue nack", st(3), 4'd7);
        ctx = 1'b1; tick();
        chk("R7", "wait retry not blocked", st(3), 4'd7);
        tick();
        rok[3] = 1'b1; tick();
        chk("R8", "retry granted", st(3), 4'd6);
        resp[3] = 1'b1; tick();
        chk("R8", "resp no stall", st(3), 4'd8);
        turn[3] = 1'b1; tick();
        chk("R8", "turn to running", st(3), 4'd0);
        resp[3] = 1'b1; tick();
        chk("R8", "resp in running ignored", st(3), 4'd0);
        chk("R11", "no pulse on ignored resp", chg[3], 1'b0);

        // R8/R3 stale response after squash on thread 0
        iok[0] = 1'b1; tick();
        chk("R8", "t0 issue", st(0), 4'd6);
        csq[0] = 1'b1; cpc[0 +: AW] = 32'h4000; cnpc[0 +: AW] = 32'h4010; tick();
        chk("R3", "squash from wait", st(0), 4'd2);
        chk("R6", "nnpc after squash", nnpc[0 +: AW], 32'h4014);
        tick();
        chk("R7", "squash done", st(0), 4'd0);
        resp[0] = 1'b1; tick();
        chk("R8", "stale resp dropped", st(0), 4'd0);

        // R9/R10 inactive thread holds
        active = 4'b1110;
        ctx = 1'b1; tick();
        chk("R9", "inactive holds", st(0), 4'd0);
        chk("R7", "active blocked", st(1), 4'd3);
        chk("R10", "inactive running not counted", sact, 1'b0);
        tick();
        chk("R9", "active released", st(1), 4'd0);

        // R10 single active thread
        active = 4'b0001;
        sset[1*NT+0] = 1'b1; tick();
        chk("R10", "only thread blocked", sact, 1'b0);
        sclr[1*NT+0] = 1'b1; tick();
        chk("R10", "only thread running", sact, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule